// File: doc/BRIEF.md
# Four-Channel Transmit Sum and Interleaved Output Stage

This block merges the tuned sample streams of four transmit channels into one wideband word stream for a converter. Each channel supplies an I and a Q word with a valid bit, and channels whose valid is low add nothing. The channel words are added together with an 18-bit word from an upstream device in a daisy chain. The total is kept at full precision, shifted right by a shared scale amount and clamped to 18 bits. The 18-bit result can then drive the cascade input of the next device in the chain. The upstream word can be masked off.

In real mode every clock produces one word built from the I parts. In complex mode a sample is taken every second clock. The I result is emitted first, then the Q result of the same sample, and a phase flag marks which one is on the bus. In split mode the lower half of the channels feeds the main output and the upper half feeds a second output, which takes the place of the cascade bus. The cascade contribution is then dropped.

Top module: `chan_combiner`

## Requirements
- R1: While reset is asserted, `out_data`, `aux_data`, `out_isq` and `aux_en` are all zero.
- R2: In real mode without split, `out_data` one clock after the inputs equals the sum of the `ch_i` words of valid channels plus the cascade word (when not masked), after scaling and clamping.
- R3: A channel whose `ch_vld` bit is 0 contributes zero to every sum. Bit k of `ch_vld` belongs to channel k, and channel k occupies bits [18k+17:18k] of `ch_i` and `ch_q`.
- R4: When `casc_mask` is 1, `casc_in` has no effect on any output.
- R5: The result is clamped to the range +131071 to -131072 and never wraps. Its sign always matches the sign of the unscaled total.
- R6: The total is arithmetically shifted right by `scale` bits (rounding toward minus infinity) before clamping.
- R7: With `split_en` at 1, `out_data` carries channels 0 and 1, `aux_data` carries channels 2 and 3, and `aux_en` is 1 one clock later. `casc_in` is ignored even if `casc_mask` is 0.
- R8: In complex mode (`cplx_en` at 1), the words alternate: first the I word of a newly taken sample (`out_isq` = 0), then the Q word of that same sample (`out_isq` = 1). A Q word is always followed by an I word or a real word.
- R9: In complex mode, the cascade word present on a clock is added to the word emitted on that clock. This applies to Q words as well.
- R10: Without split, `aux_en` is 0 and `aux_data` is 0.
- R11: On the clock that emits a Q word, the channel inputs are ignored. The Q word comes from the sample taken with the preceding I word.
- R12: In real mode, `out_isq` stays 0 and the `ch_q` words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_i | input | 72 | I words of the four channels, channel k in bits [18k+17:18k] |
| ch_q | input | 72 | Q words of the four channels, same layout |
| ch_vld | input | 4 | Per-channel valid, bit k for channel k |
| casc_in | input | 18 | Signed word from the upstream device |
| casc_mask | input | 1 | 1 drops the upstream word |
| split_en | input | 1 | 1 splits channels into two groups with two outputs |
| cplx_en | input | 1 | 1 selects interleaved I/Q output |
| scale | input | 2 | Right shift applied to the total |
| out_data | output | 18 | Main signed output word |
| out_isq | output | 1 | 1 when `out_data` holds a Q word |
| aux_data | output | 18 | Second signed output, used in split mode |
| aux_en | output | 1 | 1 when `aux_data` is driven |

## Verification
A lost or stuck interleave phase shows up at the very next clock. `out_isq` would repeat a value, or a Q word would reflect the current channel inputs instead of the held sample. For this reason, the channel inputs are changed between the I and Q clocks. A wrong held Q sum or a misrouted channel group shows up as a wrong word on the Q clock or on the auxiliary port, one clock after the sample is taken. Clamping and shift faults appear on the same single clock as the word they affect. They are tested with full-scale totals of both signs and with odd negative totals.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

    localparam int DATA_W_DEF  = 18;
    localparam int NUM_CH_DEF  = 4;
    localparam int SCALE_W_DEF = 2;

    typedef enum logic [1:0] {
        EMIT_REAL = 2'd0,
        EMIT_I    = 2'd1,
        EMIT_Q    = 2'd2
    } emit_e;

endpackage

// File: rtl/cmb_chan_sum.sv
module cmb_chan_sum #(
    parameter int DW = 18,
    parameter int N  = 2,
    parameter int SW = 21
) (
    input  logic [N-1:0]          vld,
    input  logic [N*DW-1:0]       din,
    output logic signed [SW-1:0]  sum
);
    logic signed [SW-1:0] term [N];

    for (genvar g = 0; g < N; g++) begin : g_term
        assign term[g] = vld[g] ? {{(SW-DW){din[g*DW+DW-1]}}, din[g*DW +: DW]}
                                : '0;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < N; k++) begin
            sum = sum + term[k];
        end
    end
endmodule

// File: rtl/cmb_scale_sat.sv
module cmb_scale_sat #(
    parameter int SW  = 21,
    parameter int DW  = 18,
    parameter int SCW = 2
) (
    input  logic signed [SW-1:0] din,
    input  logic [SCW-1:0]       shamt,
    output logic [DW-1:0]        dout
);
    localparam logic signed [SW-1:0] MAX_V = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] MIN_V = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [SW-1:0] shifted;

    always_comb begin
        shifted = din >>> shamt;
        if (shifted > MAX_V) begin
            dout = MAX_V[DW-1:0];
        end else if (shifted < MIN_V) begin
            dout = MIN_V[DW-1:0];
        end else begin
            dout = shifted[DW-1:0];
        end
    end

    // R5
    always_comb begin
        sat_sign_chk: assert (dout[DW-1] == din[SW-1]);
    end
endmodule

// File: rtl/chan_combiner.sv
module chan_combiner
    import cmb_pkg::*;
#(
    parameter int DW  = DATA_W_DEF,
    parameter int NCH = NUM_CH_DEF,
    parameter int SCW = SCALE_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH*DW-1:0]   ch_i,
    input  logic [NCH*DW-1:0]   ch_q,
    input  logic [NCH-1:0]      ch_vld,
    input  logic [DW-1:0]       casc_in,
    input  logic                casc_mask,
    input  logic                split_en,
    input  logic                cplx_en,
    input  logic [SCW-1:0]      scale,
    output logic [DW-1:0]       out_data,
    output logic                out_isq,
    output logic [DW-1:0]       aux_data,
    output logic                aux_en
);
    localparam int HALF = NCH / 2;
    localparam int SW   = DW + $clog2(NCH + 1);

    typedef struct packed {
        logic [DW-1:0]        out;
        logic                 isq;
        logic [DW-1:0]        aux;
        logic                 aux_en;
        logic                 qpend;
        logic signed [SW-1:0] qh_main;
        logic signed [SW-1:0] qh_aux;
    } st_t;

    st_t st_d, st_q;

    // group sums: index 0 = lower channels, 1 = upper channels
    logic signed [SW-1:0] grp_i [2];
    logic signed [SW-1:0] grp_q [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        cmb_chan_sum #(.DW(DW), .N(HALF), .SW(SW)) u_sum_i (
            .vld (ch_vld[h*HALF +: HALF]),
            .din (ch_i[h*HALF*DW +: HALF*DW]),
            .sum (grp_i[h])
        );
        cmb_chan_sum #(.DW(DW), .N(HALF), .SW(SW)) u_sum_q (
            .vld (ch_vld[h*HALF +: HALF]),
            .din (ch_q[h*HALF*DW +: HALF*DW]),
            .sum (grp_q[h])
        );
    end

    emit_e                emit;
    logic                 casc_use;
    logic signed [SW-1:0] casc_ext;
    logic signed [SW-1:0] all_i, all_q;
    logic signed [SW-1:0] main_pre, aux_pre, main_tot;
    logic [DW-1:0]        main_sat, aux_sat;

    always_comb begin
        casc_ext = {{(SW-DW){casc_in[DW-1]}}, casc_in};
        casc_use = !casc_mask && !split_en;
        all_i    = grp_i[0] + grp_i[1];
        all_q    = grp_q[0] + grp_q[1];

        if (!cplx_en) begin
            emit = EMIT_REAL;
        end else if (st_q.qpend) begin
            emit = EMIT_Q;
        end else begin
            emit = EMIT_I;
        end

        if (emit == EMIT_Q) begin
            main_pre = st_q.qh_main;
            aux_pre  = st_q.qh_aux;
        end else begin
            main_pre = split_en ? grp_i[0] : all_i;
            aux_pre  = grp_i[1];
        end
        main_tot = main_pre + (casc_use ? casc_ext : '0);
    end

    cmb_scale_sat #(.SW(SW), .DW(DW), .SCW(SCW)) u_sat_main (
        .din   (main_tot),
        .shamt (scale),
        .dout  (main_sat)
    );

    cmb_scale_sat #(.SW(SW), .DW(DW), .SCW(SCW)) u_sat_aux (
        .din   (aux_pre),
        .shamt (scale),
        .dout  (aux_sat)
    );

    always_comb begin
        st_d        = st_q;
        st_d.out    = main_sat;
        st_d.aux    = split_en ? aux_sat : '0;
        st_d.aux_en = split_en;
        st_d.isq    = (emit == EMIT_Q);
        st_d.qpend  = (emit == EMIT_I);
        if (emit == EMIT_I) begin
            st_d.qh_main = split_en ? grp_q[0] : all_q;
            st_d.qh_aux  = grp_q[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data = st_q.out;
    assign out_isq  = st_q.isq;
    assign aux_data = st_q.aux;
    assign aux_en   = st_q.aux_en;

    // R8
    q_then_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_isq |=> !out_isq);

    // R8
    i_then_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cplx_en && st_q.qpend) |=> out_isq);

    // R12
    real_no_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cplx_en |=> !out_isq);

    // R7
    split_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_en |=> aux_en);

    // R10
    aux_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_en |-> (aux_data == '0));
endmodule

// File: tb/sim_chan_combiner.sv
module sim_chan_combiner;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYC     = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [71:0] ch_i, ch_q;
    logic [3:0]  ch_vld;
    logic [17:0] casc_in;
    logic        casc_mask, split_en, cplx_en;
    logic [1:0]  scale;
    logic [17:0] out_data, aux_data;
    logic        out_isq, aux_en;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_combiner u0 (
        .clk(clk), .rst_n(rst_n), .ch_i(ch_i), .ch_q(ch_q), .ch_vld(ch_vld),
        .casc_in(casc_in), .casc_mask(casc_mask), .split_en(split_en),
        .cplx_en(cplx_en), .scale(scale), .out_data(out_data),
        .out_isq(out_isq), .aux_data(aux_data), .aux_en(aux_en)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic [3:0]  vld;
        int          c0, c1, c2, c3, casc;
        logic        mask;
        logic [1:0]  sc;
        int          exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{"R2", 4'hF, 1, 2, 3, 4, 0, 1'b1, 2'd0, 10},
        '{"R2", 4'hF, 100, -50, 25, -5, 30, 1'b0, 2'd0, 100},
        '{"R4", 4'hF, 100, -50, 25, -5, 30, 1'b1, 2'd0, 70},
        '{"R3", 4'b0101, 10, 20, 30, 40, 0, 1'b1, 2'd0, 40},
        '{"R5", 4'hF, 131071, 131071, 131071, 131071, 131071, 1'b0, 2'd0, 131071},
        '{"R5", 4'hF, -131072, -131072, -131072, -131072, -131072, 1'b0, 2'd0, -131072},
        '{"R6", 4'hF, 131071, 131071, 131071, 131071, 131071, 1'b0, 2'd3, 81919},
        '{"R6", 4'hF, -7, 0, 0, 0, 0, 1'b1, 2'd1, -4},
        '{"R6", 4'hF, 5, 0, 0, 0, 0, 1'b1, 2'd2, 1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_i(input int a, input int b, input int c, input int d);
        ch_i = {18'(d), 18'(c), 18'(b), 18'(a)};
    endtask

    task automatic set_q(input int a, input int b, input int c, input int d);
        ch_q = {18'(d), 18'(c), 18'(b), 18'(a)};
    endtask

    function automatic int sval(input logic [17:0] v);
        return int'($signed(v));
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        set_i(11, 22, 33, 44);
        set_q(5, 6, 7, 8);
        ch_vld = 4'hF; casc_in = 18'd9; casc_mask = 1'b0;
        split_en = 1'b1; cplx_en = 1'b1; scale = 2'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out_data", sval(out_data), 0);
        chk("R1 aux_data", sval(aux_data), 0);
        chk("R1 out_isq", int'(out_isq), 0);
        chk("R1 aux_en", int'(aux_en), 0);
        split_en = 1'b0; cplx_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, real mode without split
        for (int k = 0; k < NV; k++) begin
            set_i(VEC[k].c0, VEC[k].c1, VEC[k].c2, VEC[k].c3);
            set_q(999, 999, 999, 999);
            ch_vld = VEC[k].vld;
            casc_in = 18'(VEC[k].casc);
            casc_mask = VEC[k].mask;
            scale = VEC[k].sc;
            @(negedge clk);
            chk($sformatf("%s row %0d", VEC[k].tag, k), sval(out_data), VEC[k].exp);
            chk("R10 aux_en", int'(aux_en), 0);
            chk("R10 aux_data", sval(aux_data), 0);
            chk("R12 out_isq", int'(out_isq), 0);
        end

        // R8 R9 R11 complex, no split
        scale = 2'd0; ch_vld = 4'hF; casc_mask = 1'b0;
        set_i(1, 2, 3, 4); set_q(10, 20, 30, 40); casc_in = 18'd5;
        cplx_en = 1'b1;
        @(negedge clk);
        chk("R8 I word", sval(out_data), 15);
        chk("R8 I flag", int'(out_isq), 0);
        set_i(500, 500, 500, 500); set_q(900, 900, 900, 900); casc_in = 18'd7;
        @(negedge clk);
        chk("R11 Q word", sval(out_data), 107);
        chk("R8 Q flag", int'(out_isq), 1);
        casc_in = 18'(-7);
        @(negedge clk);
        chk("R8 next I word", sval(out_data), 1993);
        chk("R8 next I flag", int'(out_isq), 0);
        @(negedge clk);
        chk("R9 Q with cascade", sval(out_data), 3593);
        chk("R8 next Q flag", int'(out_isq), 1);

        // R7 split, real mode
        cplx_en = 1'b0; split_en = 1'b1;
        set_i(1, 2, 3, 4); casc_in = 18'd1000; casc_mask = 1'b0;
        @(negedge clk);
        chk("R7 main", sval(out_data), 3);
        chk("R7 aux", sval(aux_data), 7);
        chk("R7 aux_en", int'(aux_en), 1);

        // R7 R8 split, complex
        cplx_en = 1'b1; set_q(10, 20, 30, 40);
        @(negedge clk);
        chk("R7 main I", sval(out_data), 3);
        chk("R7 aux I", sval(aux_data), 7);
        set_q(0, 0, 0, 0);
        @(negedge clk);
        chk("R7 main Q", sval(out_data), 30);
        chk("R7 aux Q", sval(aux_data), 70);
        chk("R8 split Q flag", int'(out_isq), 1);

        // R10 leave split
        cplx_en = 1'b0; split_en = 1'b0; casc_in = 18'd0;
        @(negedge clk);
        chk("R10 aux_en off", int'(aux_en), 0);
        chk("R10 aux_data off", sval(aux_data), 0);
        chk("R2 back to full sum", sval(out_data), 10);

        finish_run();
    end
endmodule